// File: doc/BRIEF.md
# Inter-Word Gap Timer

This block holds off the next serial word until the receive line has rested in the Null level long enough. After the last data bit of a valid word, or after a word is abandoned, the block restarts a periodic check of the line. Each check looks at a qualified Null indication. The block counts passing checks in a row and raises a reception-enable level once enough of them have been seen. Bit decoding and word assembly are handled elsewhere. This block only decides when the next word may begin.

The line is sampled as a one-bit Null flag on every clock into a short history register. A check counts as Null only when a run of Null samples sits at both the newest end and the oldest end of that history. This guarantees a minimum Null duration and ignores brief disturbances in the middle. The check period depends on the speed select. When the receiver accepts the first bit of a new word, it clears the enable, and checking stays off until the next end-of-word event.

Top module: `wg_gap_timer`

## Requirements
- R1: A high `word_end` at a clock edge clears `rx_en` at that edge, clears the gap count and restarts the check timer. The first check happens PERIOD clocks after that edge. A second `word_end` during counting restarts the whole gap.
- R2: With `spd_low` = 0 the check period is HI_PERIOD (10) clocks. With `spd_low` = 1 it is LO_PERIOD (80) clocks. On a line that stays Null, `rx_en` rises exactly 3 × period edges after the `word_end` edge (30 or 240).
- R3: The Null history holds the last 10 `line_null` samples, and reset clears every entry to non-Null. A check passes only when the 3 newest and the 3 oldest entries are all Null. A non-Null sample in the middle four positions does not fail a check.
- R4: `rx_en` rises at the same edge as the third consecutive passing check, and at no other time.
- R5: A failing check resets the gap count to zero, so three further passing checks are needed.
- R6: A high `bit_start` at a clock edge clears `rx_en` at that edge.
- R7: After `bit_start`, no checks are made and `rx_en` stays low until a `word_end` arrives and a full gap is counted again.
- R8: After reset, `rx_en` is low and the block is counting. Because the history starts non-Null, a Null line enables reception 4 × period edges after reset release (40 at high speed).
- R9: When `word_end` and `bit_start` are high in the same cycle, `word_end` wins and counting restarts.
- R10: Once `rx_en` is high, it stays high whatever the line does, until `bit_start` or `word_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spd_low | input | 1 | 1 selects the slow check period, 0 the fast one |
| line_null | input | 1 | Per-clock sample: 1 when the line is at Null |
| word_end | input | 1 | Pulse at the end of a valid word or on abort |
| bit_start | input | 1 | Pulse when the first data bit of a word is accepted |
| rx_en | output | 1 | Reception-enable level |

## Verification
The assertions check on every cycle that the count never reaches its limit, and that a failing check empties the count. They also check that the enable rises only on a passing check with no restart or bit pulse, and that either event drops the enable on the next cycle. The exact latencies can only be shown by the bench scenarios: 30, 240 and 40 edges for the fast, slow and post-reset cases. The scenarios also show that a disturbance in the middle of the history is tolerated while one at the edge delays the enable. They cover restart in mid-gap, the priority of `word_end` over `bit_start`, and the enable holding through a busy line.

// File: rtl/wg_gap_pkg.sv
package wg_gap_pkg;
  typedef enum logic [1:0] {
    GAP_COUNT = 2'd0,
    GAP_READY = 2'd1,
    GAP_BUSY  = 2'd2
  } gap_state_t;
endpackage

// File: rtl/wg_null_qual.sv
module wg_null_qual #(
  parameter int HIST_LEN = 10,
  parameter int RUN_LEN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_null,
  output logic null_ok
);
  localparam int TOP = HIST_LEN - 1;

  logic [TOP:0] hist_q, hist_d;
  logic         new_run, old_run;

  always_comb begin
    hist_d = {hist_q[TOP-1:0], line_null};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    new_run = &hist_q[RUN_LEN-1:0];
    old_run = &hist_q[TOP:HIST_LEN-RUN_LEN];
    null_ok = new_run & old_run;
  end
endmodule

// File: rtl/wg_tick_gen.sv
module wg_tick_gen #(
  parameter int HI_PERIOD = 10,
  parameter int LO_PERIOD = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic spd_low,
  output logic tick
);
  localparam int MAXP   = (LO_PERIOD > HI_PERIOD) ? LO_PERIOD : HI_PERIOD;
  localparam int TICK_W = $clog2(MAXP);
  localparam logic [TICK_W-1:0] HI_LIM = TICK_W'(HI_PERIOD - 1);
  localparam logic [TICK_W-1:0] LO_LIM = TICK_W'(LO_PERIOD - 1);

  logic [TICK_W-1:0] cnt_q, cnt_d, lim;
  logic              at_lim;

  always_comb begin
    lim    = spd_low ? LO_LIM : HI_LIM;
    at_lim = (cnt_q >= lim);
    tick   = run & ~restart & at_lim;
    if (restart || !run) cnt_d = '0;
    else if (at_lim)     cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wg_gap_ctrl.sv
module wg_gap_ctrl
  import wg_gap_pkg::*;
#(
  parameter int GAP_CHECKS = 3,
  localparam int CNT_W = $clog2(GAP_CHECKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_end,
  input  logic             bit_start,
  input  logic             tick,
  input  logic             null_ok,
  output logic             counting,
  output logic             rx_en,
  output logic [CNT_W-1:0] gap_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CHECKS - 1);

  gap_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (word_end) begin
      st_d  = GAP_COUNT;
      cnt_d = '0;
    end else if (bit_start) begin
      st_d  = GAP_BUSY;
      cnt_d = '0;
    end else if (st_q == GAP_COUNT && tick) begin
      if (!null_ok) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        st_d  = GAP_READY;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GAP_COUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign counting = (st_q == GAP_COUNT);
  assign rx_en    = (st_q == GAP_READY);
  assign gap_cnt  = cnt_q;
endmodule

// File: rtl/wg_gap_timer.sv
module wg_gap_timer #(
  parameter int HI_PERIOD  = 10,
  parameter int LO_PERIOD  = 80,
  parameter int HIST_LEN   = 10,
  parameter int RUN_LEN    = 3,
  parameter int GAP_CHECKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spd_low,
  input  logic line_null,
  input  logic word_end,
  input  logic bit_start,
  output logic rx_en
);
  localparam int CNT_W = $clog2(GAP_CHECKS + 1);

  logic             null_ok, tick, counting;
  logic [CNT_W-1:0] gap_cnt;

  wg_null_qual #(.HIST_LEN(HIST_LEN), .RUN_LEN(RUN_LEN)) u_qual (
    .clk(clk), .rst_n(rst_n), .line_null(line_null), .null_ok(null_ok)
  );

  wg_tick_gen #(.HI_PERIOD(HI_PERIOD), .LO_PERIOD(LO_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(counting), .restart(word_end),
    .spd_low(spd_low), .tick(tick)
  );

  wg_gap_ctrl #(.GAP_CHECKS(GAP_CHECKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .word_end(word_end), .bit_start(bit_start),
    .tick(tick), .null_ok(null_ok), .counting(counting), .rx_en(rx_en),
    .gap_cnt(gap_cnt)
  );
endmodule

// File: rtl/wg_gap_timer_chk.sv
module wg_gap_timer_chk #(
  parameter int GAP_CHECKS = 3,
  parameter int CNT_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_end,
  input logic             bit_start,
  input logic             tick,
  input logic             null_ok,
  input logic             rx_en,
  input logic [CNT_W-1:0] gap_cnt
);
  // R4: the count never reaches the limit itself
  a_r4_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt < CNT_W'(GAP_CHECKS));

  // R5: a failing check empties the count
  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !null_ok) |=> (gap_cnt == '0));

  // R4: enable rises only on a passing check without restart or bit pulse
  a_r4_rise_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> $past(tick && null_ok && !word_end && !bit_start));

  // R6: a bit pulse drops the enable
  a_r6_bit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !rx_en);

  // R1: a restart drops the enable and empties the count
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (!rx_en && gap_cnt == '0));

  // R10: enable held with no event
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !word_end && !bit_start) |=> rx_en);
endmodule

bind wg_gap_timer wg_gap_timer_chk #(.GAP_CHECKS(GAP_CHECKS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_end(word_end), .bit_start(bit_start),
  .tick(tick), .null_ok(null_ok), .rx_en(rx_en), .gap_cnt(gap_cnt)
);

// File: tb/sim_wg_gap_timer.sv
module sim_wg_gap_timer;
  logic clk = 1'b0;
  logic rst_n, spd_low, line_null, word_end, bit_start;
  logic rx_en;

  int n_cmp = 0;
  int n_bad = 0;
  int lat;
  int exp_q[$];
  logic prev_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wg_gap_timer u0 (
    .clk(clk), .rst_n(rst_n), .spd_low(spd_low), .line_null(line_null),
    .word_end(word_end), .bit_start(bit_start), .rx_en(rx_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // edges since last word_end (or reset release)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat <= 0;
    else if (word_end) lat <= 0;
    else               lat <= lat + 1;
  end

  // monitor: pop an expected latency on each rise of the enable
  always @(negedge clk) begin
    if (rst_n && rx_en && !prev_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected rise", lat, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(lat == e, "R2/R4 latency", lat, e);
      end
    end
    prev_en = rx_en;
  end

  task automatic pulse_end();
    @(negedge clk); word_end = 1'b1;
    @(negedge clk); word_end = 1'b0;
    chk(rx_en == 1'b0, "R1 enable cleared", rx_en, 0);
  endtask

  task automatic wait_en(input int n, input string req);
    for (int i = 0; i < n && !rx_en; i++) @(negedge clk);
    chk(rx_en == 1'b1, req, rx_en, 1);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; spd_low = 1'b0; line_null = 1'b1;
    word_end = 1'b0; bit_start = 1'b0;
    exp_q.push_back(40);                       // R8 post-reset latency
    #20;
    chk(rx_en == 1'b0, "R8 reset state", rx_en, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_en(100, "R8 enabled after reset");

    // R10: busy line does not drop the enable
    line_null = 1'b0;
    repeat (40) @(negedge clk);
    chk(rx_en == 1'b1, "R10 hold through busy line", rx_en, 1);
    line_null = 1'b1;
    repeat (12) @(negedge clk);

    // R2 fast period
    exp_q.push_back(30);
    pulse_end();
    wait_en(60, "R2 fast enable");

    // R6 / R7
    @(negedge clk); bit_start = 1'b1;
    @(negedge clk); bit_start = 1'b0;
    chk(rx_en == 1'b0, "R6 bit drops enable", rx_en, 0);
    repeat (200) @(negedge clk);
    chk(rx_en == 1'b0, "R7 stays low until restart", rx_en, 0);

    // R2 slow period
    spd_low = 1'b1;
    exp_q.push_back(240);
    pulse_end();
    wait_en(300, "R2 slow enable");
    spd_low = 1'b0;

    // R5: dropout makes the second check fail
    exp_q.push_back(50);
    pulse_end();
    repeat (14) @(negedge clk); line_null = 1'b0;
    repeat (3) @(negedge clk);  line_null = 1'b1;
    wait_en(100, "R5 recount after miss");

    // R3: glitch in middle of history is tolerated
    exp_q.push_back(30);
    pulse_end();
    repeat (24) @(negedge clk); line_null = 1'b0;
    @(negedge clk);             line_null = 1'b1;
    wait_en(60, "R3 middle glitch ignored");

    // R3: glitch at newest end fails the check
    exp_q.push_back(60);
    pulse_end();
    repeat (27) @(negedge clk); line_null = 1'b0;
    @(negedge clk);             line_null = 1'b1;
    wait_en(100, "R3 edge glitch fails check");

    // R9: word_end beats bit_start
    exp_q.push_back(30);
    @(negedge clk); word_end = 1'b1; bit_start = 1'b1;
    @(negedge clk); word_end = 1'b0; bit_start = 1'b0;
    chk(rx_en == 1'b0, "R9 enable cleared", rx_en, 0);
    wait_en(60, "R9 counting restarted");

    // R1: restart in mid-gap
    exp_q.push_back(30);
    pulse_end();
    repeat (15) @(negedge clk);
    chk(rx_en == 1'b0, "R1 low mid-gap", rx_en, 0);
    pulse_end();
    wait_en(60, "R1 restart latency");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all rises seen", exp_q.size(), 0);
    finish_run();
  end
endmodule